// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block holds a small set of independent down-counting timer channels behind a simple word-addressed register bus. Each channel counts down from a programmed reload value, one count per clock. When the count reaches zero it raises an event flag, takes the reload value again and carries on counting. Every channel is therefore periodic on its own, and software never has to restart it. Each channel drives one level interrupt line, and that line is masked by the channel's own interrupt-enable bit.

A channel other than the first can be switched into cascade mode. In that mode it steps once for every underflow of the channel below it, so two channels together form a counter twice as wide. A module-level halt bit freezes every channel at once, and it is set after reset. Software reads the live count at any time. A channel left free-running from an all-ones reload therefore works as a timestamp source once its value is inverted.

Top module: `pit_timer`

## Requirements
- R1: After reset the module-control word (offset 0x000) reads 0x2, which means the halt bit (bit 1) is set. Every channel register reads 0 and all interrupt lines are low.
- R2: Channel n occupies offsets 0x100 + 0x10·n. Its reload value is at +0x0, its live count at +0x4, its control word at +0x8 (bit 0 run, bit 1 interrupt enable, bit 2 cascade) and its event flag at +0xC, bit 0.
- R3: Reads of offsets that map to no register return 0. Writes to those offsets, and writes to the live-count register, change nothing.
- R4: While the halt bit is 1, no running channel changes its count.
- R5: In the clock after the run bit goes from 0 to 1, the count takes the reload value. While the run bit is 0 the count holds its last value.
- R6: A running channel decrements by one per step. A step taken at count 0 reloads the count and sets the flag. With reload value L the period is L+1 steps.
- R7: Writing the reload register leaves the count in progress untouched, and the new value is taken at the next reload. Clearing and then setting the run bit restarts the count from the new value.
- R8: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged. A flag being set in the same cycle as a clear stays set.
- R9: The interrupt line of a channel is high exactly while its flag and its interrupt enable are both 1. It stays high until the flag is cleared.
- R10: In cascade mode a channel steps once per underflow of the channel below it, and it holds while that channel does not underflow.
- R11: Channel 0 has no cascade bit. Its control bit 2 reads 0 and channel 0 steps on every clock.
- R12: The live-count register returns the current count. A channel loaded with all ones runs down from 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | NUM_CH | Per-channel level interrupt lines |

## Verification
The hardest state to reach is a cascaded channel that is armed and loaded but receives no steps. To get there, the lower channel is stopped, the upper channel is started in cascade mode and is seen to hold its count. Only then is the lower channel started, and each underflow is observed to move the upper count by exactly one, up to its own reload and flag. The reload-write case also needs care: a new reload value is written in the middle of a short period, and the stimulus is timed so that one read falls before the wrap and one falls after it.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned MCR_OFS    = 'h000;
   localparam int unsigned CH_BASE    = 'h100;
   localparam int unsigned CH_STRIDE  = 'h010;

   localparam logic [1:0] SUB_LOAD  = 2'd0;
   localparam logic [1:0] SUB_COUNT = 2'd1;
   localparam logic [1:0] SUB_CTRL  = 2'd2;
   localparam logic [1:0] SUB_FLAG  = 2'd3;

   localparam int unsigned MCR_HALT_BIT = 1;
   localparam int unsigned CTL_RUN_BIT  = 0;
   localparam int unsigned CTL_IE_BIT   = 1;
   localparam int unsigned CTL_CAS_BIT  = 2;

   typedef struct packed {
      logic cascade;
      logic ie;
      logic run;
   } pit_ctl_t;
endpackage

// File: rtl/pit_decode.sv
module pit_decode #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NUM_CH = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              mcr_hit,
   output logic [NUM_CH-1:0] ch_hit,
   output logic [1:0]        sub
);
   import pit_pkg::*;

   assign mcr_hit = (addr == ADDR_W'(MCR_OFS));
   assign sub     = addr[3:2];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] CH_ADR = ADDR_W'(CH_BASE + CH_STRIDE * i);
      assign ch_hit[i] = (addr[ADDR_W-1:4] == CH_ADR[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
   end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
   parameter int unsigned CNT_W     = 32,
   parameter bit          HAS_CHAIN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  halt,
   input  logic                  wr_load,
   input  logic                  wr_ctrl,
   input  logic                  wr_flag,
   input  logic [31:0]           wdata,
   input  logic                  prev_uf,
   output logic [CNT_W-1:0]      load_q,
   output logic [CNT_W-1:0]      cnt_q,
   output pit_pkg::pit_ctl_t     ctl_q,
   output logic                  flag_q,
   output logic                  arm_q,
   output logic                  tick,
   output logic                  uf,
   output logic                  irq
);
   import pit_pkg::*;

   localparam logic CHAIN_OK = 1'(HAS_CHAIN);

   logic start, step;
   logic unused_wbits;
   assign unused_wbits = ^wdata;

   if (HAS_CHAIN) begin : g_cascade
      assign tick = ctl_q.cascade ? prev_uf : 1'b1;
   end else begin : g_solo
      logic unused_prev;
      assign unused_prev = prev_uf;
      assign tick        = 1'b1;
   end

   assign start = ctl_q.run & ~arm_q;
   assign step  = ctl_q.run & arm_q & ~halt & tick;
   assign uf    = step & (cnt_q == '0);
   assign irq   = flag_q & ctl_q.ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         cnt_q  <= '0;
         ctl_q  <= '0;
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         arm_q <= ctl_q.run;
         if (wr_load) load_q <= wdata[CNT_W-1:0];
         if (wr_ctrl) begin
            ctl_q.run     <= wdata[CTL_RUN_BIT];
            ctl_q.ie      <= wdata[CTL_IE_BIT];
            ctl_q.cascade <= wdata[CTL_CAS_BIT] & CHAIN_OK;
         end
         if (start)       cnt_q <= load_q;
         else if (uf)     cnt_q <= load_q;
         else if (step)   cnt_q <= cnt_q - CNT_W'(1);
         if (uf)                         flag_q <= 1'b1;
         else if (wr_flag && wdata[0])   flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pit_rdmux.sv
module pit_rdmux #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32
) (
   input  logic                          mcr_hit,
   input  logic [NUM_CH-1:0]             ch_hit,
   input  logic [1:0]                    sub,
   input  logic                          halt,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  load_all,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all,
   input  logic [NUM_CH-1:0][2:0]        ctl_all,
   input  logic [NUM_CH-1:0]             flag_all,
   output logic [31:0]                   rdata
);
   import pit_pkg::*;

   always_comb begin
      rdata = '0;
      if (mcr_hit) rdata[MCR_HALT_BIT] = halt;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_hit[i]) begin
            case (sub)
               SUB_LOAD:  rdata = 32'(load_all[i]);
               SUB_COUNT: rdata = 32'(cnt_all[i]);
               SUB_CTRL:  rdata = {29'd0, ctl_all[i]};
               default:   rdata = {31'd0, flag_all[i]};
            endcase
         end
      end
   end
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   import pit_pkg::*;

   localparam int unsigned CH_SPAN    = NUM_CH * CH_STRIDE;
   localparam int unsigned MIN_ADDR_W = $clog2(CH_BASE + CH_SPAN);

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("pit_timer: NUM_CH must be 1..16");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_w
      $error("pit_timer: CNT_W must be 2..32");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_a
      $error("pit_timer: ADDR_W too narrow for channel map");
   end

   logic                         mcr_hit;
   logic [NUM_CH-1:0]            ch_hit;
   logic [1:0]                   sub;
   logic                         halt_q;
   logic [NUM_CH-1:0][CNT_W-1:0] load_all, cnt_all;
   logic [NUM_CH-1:0][2:0]       ctl_all;
   logic [NUM_CH-1:0]            flag_all, arm_all, tick_all, uf_all;
   logic [NUM_CH-1:0]            run_all, cas_all;

   pit_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr    (bus_addr),
      .mcr_hit (mcr_hit),
      .ch_hit  (ch_hit),
      .sub     (sub)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                halt_q <= 1'b1;
      else if (bus_wr && mcr_hit) halt_q <= bus_wdata[MCR_HALT_BIT];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pit_ctl_t ctl;
      logic     prev;
      if (i == 0) begin : g_first
         assign prev = 1'b0;
      end else begin : g_next
         assign prev = uf_all[i-1];
      end

      pit_channel #(.CNT_W(CNT_W), .HAS_CHAIN(i != 0)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .halt    (halt_q),
         .wr_load (bus_wr & ch_hit[i] & (sub == SUB_LOAD)),
         .wr_ctrl (bus_wr & ch_hit[i] & (sub == SUB_CTRL)),
         .wr_flag (bus_wr & ch_hit[i] & (sub == SUB_FLAG)),
         .wdata   (bus_wdata),
         .prev_uf (prev),
         .load_q  (load_all[i]),
         .cnt_q   (cnt_all[i]),
         .ctl_q   (ctl),
         .flag_q  (flag_all[i]),
         .arm_q   (arm_all[i]),
         .tick    (tick_all[i]),
         .uf      (uf_all[i]),
         .irq     (irq[i])
      );

      assign ctl_all[i] = ctl;
      assign run_all[i] = ctl.run;
      assign cas_all[i] = ctl.cascade;
   end

   pit_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_rd (
      .mcr_hit  (mcr_hit),
      .ch_hit   (ch_hit),
      .sub      (sub),
      .halt     (halt_q),
      .load_all (load_all),
      .cnt_all  (cnt_all),
      .ctl_all  (ctl_all),
      .flag_all (flag_all),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         halt,
   input logic [NUM_CH-1:0]            run,
   input logic [NUM_CH-1:0]            arm,
   input logic [NUM_CH-1:0]            cas,
   input logic [NUM_CH-1:0]            tick,
   input logic [NUM_CH-1:0]            uf,
   input logic [NUM_CH-1:0]            flag,
   input logic [NUM_CH-1:0][CNT_W-1:0] ld,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(halt && run[i] && arm[i]) |-> cnt[i] == $past(cnt[i]));

      assert_reload_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(uf[i]) |-> (cnt[i] == $past(ld[i])) && flag[i]);

      assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(run[i] && arm[i] && !halt && tick[i] && cnt[i] != '0)
         |-> cnt[i] == $past(cnt[i]) - CNT_W'(1));

      assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(flag[i]) && flag[i]) |-> $past(uf[i]));

      assert_flag_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(flag[i]) && !flag[i]) |-> !$past(uf[i]));

      if (i > 0) begin : g_cas
         assert_cascade_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cas[i] && run[i] && arm[i] && !uf[i-1]) |-> $stable(cnt[i]));
      end
   end
endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .halt (halt_q),
   .run  (run_all),
   .arm  (arm_all),
   .cas  (cas_all),
   .tick (tick_all),
   .uf   (uf_all),
   .flag (flag_all),
   .ld   (load_all),
   .cnt  (cnt_all)
);

// File: tb/pit_timer_bench.sv
`timescale 1ns/100ps
module pit_timer_bench;
   localparam int unsigned NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pit_timer u_pit_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct {
      logic [31:0] exp;
      bit          is_irq;
      string       tag;
      logic [11:0] adr;
   } item_t;

   item_t exp_q[$];
   event  chk_ev;

   function automatic logic [11:0] ra(input int ch, input int off);
      return 12'(32'h100 + 32'h10 * ch + off);
   endfunction

   // monitor: compares the design's result against queued expectations
   initial begin
      forever begin
         @(chk_ev);
         #0.5;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = it.is_irq ? 32'(irq) : bus_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.adr, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      exp_q.push_back('{e, 1'b0, tag, a});
      ->chk_ev;
      #1;
   endtask

   task automatic ck_irq(input logic [31:0] e, input string tag);
      exp_q.push_back('{e, 1'b1, tag, 12'h0});
      ->chk_ev;
      #1;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      rd(12'h000, 32'h2, "R1 halt set");
      rd(ra(0,8), 0, "R1 ctrl0");
      rd(ra(0,4), 0, "R1 count0");
      rd(ra(0,0), 0, "R1 load0");
      rd(ra(3,12), 0, "R1 flag3");
      ck_irq(0, "R1 irq");

      // R3 unmapped and read-only
      wr(12'h004, 32'hFFFF_FFFF);
      rd(12'h004, 0, "R3 hole");
      rd(12'h000, 32'h2, "R3 mcr untouched");
      wr(12'h140, 32'h5);
      rd(12'h140, 0, "R3 beyond map");
      wr(ra(0,4), 32'h55);
      rd(ra(0,4), 0, "R3 count read-only");

      // R5/R4 start while halted
      wr(ra(0,0), 5);
      wr(ra(0,8), 1);
      cyc(1); rd(ra(0,4), 5, "R5 load on enable");
      cyc(3); rd(ra(0,4), 5, "R4 halted hold");
      wr(12'h000, 0);
      rd(ra(0,4), 5, "R4 release edge");
      cyc(1); rd(ra(0,4), 4, "R6 step");
      cyc(4); rd(ra(0,4), 0, "R6 zero");
      rd(ra(0,12), 0, "R6 flag not yet");
      cyc(1); rd(ra(0,4), 5, "R6 reload period");
      rd(ra(0,12), 1, "R6 flag set");
      ck_irq(0, "R9 masked");

      // stop, R9 / R8
      wr(ra(0,8), 2);
      rd(ra(0,4), 3, "R5 stop value");
      cyc(3); rd(ra(0,4), 3, "R5 hold");
      ck_irq(1, "R9 irq high");
      wr(ra(0,12), 0);
      rd(ra(0,12), 1, "R8 write0 no effect");
      ck_irq(1, "R9 irq stays");
      wr(ra(0,12), 1);
      rd(ra(0,12), 0, "R8 w1c");
      ck_irq(0, "R9 irq drops");

      // R7 reload write
      wr(ra(1,0), 3);
      wr(ra(1,8), 1);
      cyc(1); rd(ra(1,4), 3, "R7 start");
      wr(ra(1,0), 10);
      rd(ra(1,4), 1, "R7 count undisturbed");
      rd(ra(1,0), 10, "R2 load readback");
      cyc(2); rd(ra(1,4), 10, "R7 new value at reload");
      rd(ra(1,12), 1, "R6 flag1");
      wr(ra(1,0), 20);
      wr(ra(1,8), 0);
      wr(ra(1,8), 1);
      cyc(1); rd(ra(1,4), 20, "R7 restart");

      // R10 cascade
      wr(ra(1,8), 0);
      wr(ra(1,0), 2);
      wr(ra(2,0), 1);
      wr(ra(2,8), 5);
      cyc(1); rd(ra(2,4), 1, "R10 loaded");
      cyc(2); rd(ra(2,4), 1, "R10 waits");
      wr(ra(1,8), 1);
      cyc(1); rd(ra(1,4), 2, "R10 lower start");
      cyc(3); rd(ra(2,4), 0, "R10 one underflow");
      rd(ra(2,12), 0, "R10 no flag yet");
      cyc(3); rd(ra(2,4), 1, "R10 reload");
      rd(ra(2,12), 1, "R10 flag");

      // R11 channel 0 no cascade
      wr(ra(0,0), 2);
      wr(ra(0,8), 5);
      rd(ra(0,8), 1, "R11 bit2 reads 0");
      cyc(2); rd(ra(0,4), 1, "R11 counts per clock");

      // R12 timestamp, R4 halt while running
      wr(ra(3,0), 32'hFFFF_FFFF);
      wr(ra(3,8), 1);
      cyc(1); rd(ra(3,4), 32'hFFFF_FFFF, "R12 all ones");
      cyc(3); rd(ra(3,4), 32'hFFFF_FFFC, "R12 live");
      wr(12'h000, 32'h2);
      rd(ra(3,4), 32'hFFFF_FFFA, "R4 halt edge");
      cyc(3); rd(ra(3,4), 32'hFFFF_FFFA, "R4 frozen");
      rd(12'h000, 32'h2, "R2 mcr readback");

      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule